// File: doc/BRIEF.md
# Energy Efficient Ethernet Low-Power Idle Controller

This block decides when the transmit side of an Ethernet MAC may signal low-power idle (LPI) and when it must leave it. Software provides an enable bit, the link status it has read from the PHY and one packed timer word. The MAC provides a transmit-pending flag and a free-running one-microsecond tick. The block raises `tx_lpi_o` only after the link has been good for a programmed number of milliseconds with no traffic waiting. When traffic, a disable or a link loss ends LPI, the block holds `tx_ready_o` low for a programmed wake time in microseconds before normal transmission may resume.

The block also watches the receive-side LPI indication. It records four kinds of transition, entering and leaving LPI on the transmit and on the receive side, as sticky status flags. A status read strobe clears the flags. The interrupt line is high whenever any flag is set.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset `tx_lpi_o` is 0, `tx_ready_o` is 1, `status_o` is 0 and `irq_o` is 0.
- R2: `timer_ctrl_i[15:0]` is the wake time in microsecond ticks and `timer_ctrl_i[26:16]` is the link-stable time in milliseconds. Bits 31:27 have no effect.
- R3: `tx_lpi_o` rises only when LPI is enabled, the link is up, no transmit is pending and the link has stayed up for the link-stable time. One millisecond is `TICKS_PER_MS` microsecond ticks. With a tick on every clock, LS>0 and the block already waiting, `tx_lpi_o` rises on clock edge 4·LS+1 counted from the edge that first samples link up (for `TICKS_PER_MS`=4).
- R4: A clock edge that samples link down restarts the link-stable count, including the partial millisecond.
- R5: While in LPI, a pending transmit, a disable or a link loss drops `tx_lpi_o` on the next edge.
- R6: On leaving LPI the wake counter loads TW and drops by one per tick. `tx_ready_o` stays low until the edge after it reaches zero. With a tick on every clock it is high again after TW+2 edges counted from the exit edge.
- R7: `status_o` bit 0 is set when transmit LPI is entered, bit 1 when it is left, bit 2 on a rise of `rx_lpi_i` and bit 3 on a fall. Each bit stays set until it is read.
- R8: An edge with `stat_rd_i` high clears every flag, except a flag whose event occurs on that same edge, which stays set.
- R9: `irq_o` is high exactly when at least one status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| lpi_en_i | input | 1 | LPI enable from software |
| link_up_i | input | 1 | PHY link status written by software |
| tx_pending_i | input | 1 | MAC has a frame to send |
| rx_lpi_i | input | 1 | Receive path is in LPI |
| timer_ctrl_i | input | 32 | Packed wake time and link-stable time |
| stat_rd_i | input | 1 | Status read strobe, clears flags |
| tx_lpi_o | output | 1 | Request to transmit the LPI pattern |
| tx_ready_o | output | 1 | Normal transmission allowed |
| status_o | output | 4 | Sticky transition flags |
| irq_o | output | 1 | Interrupt, OR of the flags |

## Verification
The assertions assume that every input is synchronous to `clk_i`, that `us_tick_i` is a pulse no longer than one cycle, and that `timer_ctrl_i` stays constant while a timer is running. The stimulus changes all inputs only on the falling edge. It keeps the tick high on every cycle, so elapsed time can be counted in edges. It rewrites the timer word only while no wake countdown is active and after the link has been dropped, so the link-stable count starts from zero under the new value.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_WAIT_LINK = 2'd1,
    ST_LPI       = 2'd2,
    ST_WAKE      = 2'd3
  } lpi_state_e;

  localparam int unsigned FLAG_TX_ENTER = 0;
  localparam int unsigned FLAG_TX_EXIT  = 1;
  localparam int unsigned FLAG_RX_ENTER = 2;
  localparam int unsigned FLAG_RX_EXIT  = 3;
  localparam int unsigned NUM_FLAGS     = 4;
endpackage

// File: rtl/lpi_ms_div.sv
module lpi_ms_div #(
  parameter int unsigned TICKS_PER_MS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic us_tick_i,
  output logic ms_tick_o
);
  localparam int unsigned DIV_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_MS - 1);

  logic [DIV_W-1:0] div_q;
  logic             at_last;

  assign at_last   = (div_q == DIV_LAST);
  assign ms_tick_o = !clr_i && us_tick_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (clr_i)     div_q <= '0;
    else if (us_tick_i) div_q <= at_last ? '0 : div_q + 1'b1;
  end

  assert_div_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(div_q) < TICKS_PER_MS);

  assert_div_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_q == '0));
endmodule

// File: rtl/lpi_ls_timer.sv
module lpi_ls_timer #(
  parameter int unsigned LS_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            link_i,
  input  logic            ms_tick_i,
  input  logic [LS_W-1:0] ls_val_i,
  output logic            ls_ok_o
);
  logic [LS_W-1:0] ls_cnt_q;

  // saturates at the programmed value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ls_cnt_q <= '0;
    else if (!link_i)                           ls_cnt_q <= '0;
    else if (ms_tick_i && ls_cnt_q < ls_val_i)  ls_cnt_q <= ls_cnt_q + 1'b1;
  end

  assign ls_ok_o = link_i && (ls_cnt_q >= ls_val_i);

  assert_ls_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_i |=> (ls_cnt_q == '0));

  assert_ls_no_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_i && !ms_tick_i && $past(link_i)) |=> $stable(ls_cnt_q));
endmodule

// File: rtl/lpi_wake_timer.sv
module lpi_wake_timer #(
  parameter int unsigned TW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TW_W-1:0] tw_val_i,
  input  logic            run_i,
  input  logic            us_tick_i,
  output logic            done_o
);
  logic [TW_W-1:0] tw_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    tw_cnt_q <= '0;
    else if (load_i)                                tw_cnt_q <= tw_val_i;
    else if (run_i && us_tick_i && tw_cnt_q != '0)  tw_cnt_q <= tw_cnt_q - 1'b1;
  end

  assign done_o = (tw_cnt_q == '0);

  assert_tw_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (tw_cnt_q == $past(tw_val_i)));

  assert_tw_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !us_tick_i) |=> $stable(tw_cnt_q));
endmodule

// File: rtl/lpi_sticky_flags.sv
module lpi_sticky_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // a new event wins over a clearing read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_q[g] <= 1'b0;
      else if (set_i[g]) flags_q[g] <= 1'b1;
      else if (rd_i)     flags_q[g] <= 1'b0;
    end

    assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_q[g]);

    assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[g] && !rd_i) |=> flags_q[g]);
  end

  assign flags_o = flags_q;

  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && set_i == '0) |=> (flags_q == '0));
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned TW_W         = 16,
  parameter int unsigned LS_W         = 11,
  parameter int unsigned CTRL_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              us_tick_i,
  input  logic              lpi_en_i,
  input  logic              link_up_i,
  input  logic              tx_pending_i,
  input  logic              rx_lpi_i,
  input  logic [CTRL_W-1:0] timer_ctrl_i,
  input  logic              stat_rd_i,
  output logic              tx_lpi_o,
  output logic              tx_ready_o,
  output logic [3:0]        status_o,
  output logic              irq_o
);
  localparam int unsigned TW_LSB = 0;
  localparam int unsigned LS_LSB = 16;
  localparam int unsigned TOP_LSB = LS_LSB + LS_W;

  lpi_state_e state_q, state_d;
  logic [TW_W-1:0] tw_val;
  logic [LS_W-1:0] ls_val;
  logic ms_tick, ls_ok, tw_done, tw_load;
  logic rx_q;
  logic [NUM_FLAGS-1:0] events;
  logic unused_ctrl_bits;

  assign tw_val = timer_ctrl_i[TW_LSB +: TW_W];
  assign ls_val = timer_ctrl_i[LS_LSB +: LS_W];
  assign unused_ctrl_bits = ^(timer_ctrl_i >> TOP_LSB);

  lpi_ms_div #(.TICKS_PER_MS(TICKS_PER_MS)) u_ms_div (
    .clk_i, .rst_ni, .clr_i(!link_up_i), .us_tick_i, .ms_tick_o(ms_tick)
  );

  lpi_ls_timer #(.LS_W(LS_W)) u_ls_timer (
    .clk_i, .rst_ni, .link_i(link_up_i), .ms_tick_i(ms_tick),
    .ls_val_i(ls_val), .ls_ok_o(ls_ok)
  );

  lpi_wake_timer #(.TW_W(TW_W)) u_wake_timer (
    .clk_i, .rst_ni, .load_i(tw_load), .tw_val_i(tw_val),
    .run_i(state_q == ST_WAKE), .us_tick_i, .done_o(tw_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:    if (lpi_en_i && !tx_pending_i) state_d = ST_WAIT_LINK;
      ST_WAIT_LINK: if (!lpi_en_i || tx_pending_i) state_d = ST_ACTIVE;
                    else if (ls_ok)                state_d = ST_LPI;
      ST_LPI:       if (!lpi_en_i || tx_pending_i || !link_up_i) state_d = ST_WAKE;
      ST_WAKE:      if (tw_done) state_d = ST_ACTIVE;
      default:      state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      rx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rx_q    <= rx_lpi_i;
    end
  end

  assign tw_load = (state_q == ST_LPI) && (state_d == ST_WAKE);

  assign events[FLAG_TX_ENTER] = (state_q != ST_LPI) && (state_d == ST_LPI);
  assign events[FLAG_TX_EXIT]  = tw_load;
  assign events[FLAG_RX_ENTER] = rx_lpi_i && !rx_q;
  assign events[FLAG_RX_EXIT]  = !rx_lpi_i && rx_q;

  lpi_sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i(events), .rd_i(stat_rd_i), .flags_o(status_o)
  );

  assign tx_lpi_o   = (state_q == ST_LPI);
  assign tx_ready_o = (state_q == ST_ACTIVE) || (state_q == ST_WAIT_LINK);
  assign irq_o      = |status_o;

  assert_entry_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_lpi_o) |-> $past(lpi_en_i && link_up_i && !tx_pending_i && ls_ok));

  assert_lpi_leave_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lpi_o && (tx_pending_i || !lpi_en_i || !link_up_i)) |=> !tx_lpi_o);

  assert_wake_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_lpi_o) |-> !tx_ready_o);

  assert_tx_entry_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_lpi_o) |-> status_o[FLAG_TX_ENTER]);

  assert_irq_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|events));
endmodule

// File: tb/eee_lpi_ctrl_tb.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_tb;
  localparam int TPM = 4;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni = 1'b0, us_tick = 1'b0, lpi_en = 1'b0, link_up = 1'b0;
  logic tx_pending = 1'b0, rx_lpi = 1'b0, stat_rd = 1'b0;
  logic [31:0] timer_ctrl = '0;
  logic tx_lpi, tx_ready, irq;
  logic [3:0] status;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] exp_q[$];

  eee_lpi_ctrl #(.TICKS_PER_MS(TPM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .us_tick_i(us_tick), .lpi_en_i(lpi_en),
    .link_up_i(link_up), .tx_pending_i(tx_pending), .rx_lpi_i(rx_lpi),
    .timer_ctrl_i(timer_ctrl), .stat_rd_i(stat_rd), .tx_lpi_o(tx_lpi),
    .tx_ready_o(tx_ready), .status_o(status), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic read_status(input logic [3:0] e);
    exp_q.push_back(e);
    stat_rd = 1'b1;
    edges(1);
    stat_rd = 1'b0;
  endtask

  // monitor: compares the flags seen while a read strobe is active
  always begin
    @(negedge clk);
    #1;
    if (rst_ni && stat_rd) begin
      if (exp_q.size() == 0) check("R7 unexpected read", {28'd0, status}, 32'hx);
      else check("R7 status at read", {28'd0, status}, {28'd0, exp_q.pop_front()});
    end
  end

  task automatic finish_run();
    if (exp_q.size() != 0) check("R7 unread expectations", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    timer_ctrl = (32'd3 << 16) | 32'd6;  // LS=3 ms, TW=6 us
    edges(3);
    rst_ni = 1'b1;
    edges(1);
    check("R1 tx_lpi", tx_lpi, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 status", status, 0);
    check("R1 irq", irq, 0);

    us_tick = 1'b1;
    lpi_en  = 1'b1;
    edges(1);

    // R4: a link drop restarts the stable count
    link_up = 1'b1;
    edges(8);
    link_up = 1'b0;
    edges(1);
    link_up = 1'b1;
    edges(12);
    check("R4 no entry before full LS", tx_lpi, 0);
    edges(1);
    check("R3 entry after LS", tx_lpi, 1);
    check("R9 irq with flag", irq, 1);
    read_status(4'b0001);
    check("R8 cleared after read", status, 0);
    check("R9 irq low after read", irq, 0);

    // R5/R6 exit on pending transmit
    tx_pending = 1'b1;
    edges(1);
    check("R5 exit on pending", tx_lpi, 0);
    check("R6 hold on exit", tx_ready, 0);
    edges(6);
    check("R6 still holding at TW+1", tx_ready, 0);
    edges(1);
    check("R6 ready at TW+2", tx_ready, 1);
    read_status(4'b0010);

    tx_pending = 1'b0;
    edges(2);
    check("R3 re-entry with stable link", tx_lpi, 1);

    lpi_en = 1'b0;
    edges(1);
    check("R5 exit on disable", tx_lpi, 0);
    edges(7);
    check("R6 ready after wake", tx_ready, 1);
    read_status(4'b0011);

    lpi_en = 1'b1;
    edges(2);
    check("R3 entry again", tx_lpi, 1);
    link_up = 1'b0;
    edges(1);
    check("R5 exit on link loss", tx_lpi, 0);
    edges(40);
    check("R3 no entry without link", tx_lpi, 0);
    read_status(4'b0011);

    tx_pending = 1'b1;
    link_up = 1'b1;
    edges(40);
    check("R3 no entry with pending", tx_lpi, 0);
    check("R3 ready with pending", tx_ready, 1);

    // R2: new field values, junk in bits 31:27
    timer_ctrl = 32'hF801_0002;  // LS=1 ms, TW=2 us
    link_up = 1'b0;
    edges(1);
    link_up = 1'b1;
    tx_pending = 1'b0;
    edges(4);
    check("R2 LS field no entry yet", tx_lpi, 0);
    edges(1);
    check("R2 LS field entry", tx_lpi, 1);
    tx_pending = 1'b1;
    edges(1);
    check("R2 exit", tx_lpi, 0);
    edges(2);
    check("R2 TW field hold", tx_ready, 0);
    edges(1);
    check("R2 TW field ready", tx_ready, 1);
    read_status(4'b0011);

    // receive transitions and read/event collision
    rx_lpi = 1'b1;
    edges(1);
    check("R7 rx entry flag", status, 4'b0100);
    check("R9 irq on rx flag", irq, 1);
    exp_q.push_back(4'b0100);
    stat_rd = 1'b1;
    rx_lpi = 1'b0;
    edges(1);
    stat_rd = 1'b0;
    check("R8 event beats read", status, 4'b1000);
    read_status(4'b1000);
    check("R8 clear after read", status, 0);

    done = 1;
    finish_run();
  end
endmodule